// File: doc/BRIEF.md
# Video Timing Reference Formatter

This block produces the byte stream of a digital component video interface: one byte per line-locked clock. A line counter with a software-set total length decides where in each line the two four-byte timing references go. The first reference marks the start of active video and the second marks its end. The active payload goes between the two references. The gap after the end reference is filled with the standard blanking pair.

Two region modes are offered. In the fixed mode the active region always spans 1440 clocks, and the start reference begins at a programmed count. In raw mode, two 8-bit start and stop values place both references directly. Payload cycles without a valid qualifier are filled with a null byte. Payload bytes that could imitate a reference preamble are clamped.

The field and vertical-blanking flags are captured once per line, when the end reference begins. The end reference and the following start reference both carry the captured values. A test override replaces the whole stream with converter bytes, and no references are inserted while it is set.

Top module: `vid_ref_fmt`

## Requirements
- R1: While `rst` is high at a clock edge, `vout` becomes 10h, the line count returns to 0, and the captured flags become field 0, vertical blanking 1. The line then starts at count 0 in blanking, so the first blanking byte after reset is 80h.
- R2: Each timing reference is the bytes FFh, 00h, 00h, XY. In XY, bit 7 = 1, bit 6 = F, bit 5 = V and bit 4 = H, where H = 0 in the start reference and H = 1 in the end reference. Bits 3..0 are the protection bits, with bit 3 = V^H, bit 2 = F^H, bit 1 = F^V and bit 0 = F^V^H.
- R3: In fixed mode (`raw_mode` = 0), the count runs from 0 to `line_len`-1 and then wraps. The start reference occupies counts `sav_pos` to `sav_pos`+3. The active region occupies the next 1440 counts, and the end reference occupies the 4 counts after that.
- R4: In raw mode, the start reference begins at count 4·`raw_start` and the end reference begins at count 4·`raw_stop`. The counts between them are the active region.
- R5: Every count outside both references and the active region emits the blanking pair. The pair alternates 80h and 10h, and it starts with 80h after each end reference and after reset.
- R6: In an active count with `pay_valid` = 0, the output is 00h.
- R7: In an active count with `pay_valid` = 1, the output is `pay_data`, except that FFh becomes FEh and 00h becomes 01h.
- R8: F and V are sampled from `fld_in` and `vblk_in` only in the count where the end reference's first byte is due. Changes to `fld_in` and `vblk_in` at other times have no effect until the next end reference.
- R9: While `test_bypass` is 1, `vout` is `adc_byte` from one clock earlier, and no references appear. The line count and the flag state keep advancing underneath.
- R10: Every output is registered. The byte for count n, and for the inputs presented in that count, appears on `vout` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-locked byte clock |
| rst | input | 1 | Synchronous active-high reset |
| line_len | input | CW | Total clocks per line |
| sav_pos | input | CW | Count of the start reference's first byte in fixed mode |
| raw_mode | input | 1 | 1 selects the raw region positions |
| raw_start | input | RW | Raw start reference position, in units of 4 counts |
| raw_stop | input | RW | Raw end reference position, in units of 4 counts |
| test_bypass | input | 1 | Test override: pass converter bytes through |
| adc_byte | input | 8 | Converter byte used in test override |
| fld_in | input | 1 | Field flag |
| vblk_in | input | 1 | Vertical blanking flag |
| pay_data | input | 8 | Active payload byte |
| pay_valid | input | 1 | Payload qualifier |
| vout | output | 8 | Formatted output byte |

## Verification
Every result of this block is due exactly one clock after the count that produces it. A reference byte, a blanking byte, a payload byte and a bypassed converter byte all follow that rule. The bench drives the inputs for count n at a falling edge and waits for one rising edge. At the next falling edge it compares `vout` with the byte that the requirement model predicts for count n. Flag capture is checked the same way: the bench changes `fld_in` and `vblk_in` at the start of every line, so a start reference that shows the new values one line too early is caught.

// File: rtl/vrf_pkg.sv
package vrf_pkg;
  localparam int BYTE_W   = 8;
  localparam int MARK_LEN = 4;

  typedef enum logic [1:0] {
    SEG_BLANK = 2'd0,
    SEG_SAV   = 2'd1,
    SEG_ACT   = 2'd2,
    SEG_EAV   = 2'd3
  } seg_t;

  // Status byte of a timing reference, with its protection bits
  function automatic logic [BYTE_W-1:0] ref_word(input logic f, input logic v, input logic h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  // Keep payload away from the preamble values
  function automatic logic [BYTE_W-1:0] clamp_byte(input logic [BYTE_W-1:0] d);
    if (d == 8'hFF) return 8'hFE;
    if (d == 8'h00) return 8'h01;
    return d;
  endfunction
endpackage

// File: rtl/vrf_line_ctr.sv
module vrf_line_ctr #(
  parameter int CW = 12
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] line_len,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] last_cnt;
  assign last_cnt = line_len - CW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (cnt >= last_cnt) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/vrf_seg_dec.sv
module vrf_seg_dec
  import vrf_pkg::*;
#(
  parameter int CW         = 12,
  parameter int RW         = 8,
  parameter int ACTIVE_LEN = 1440
) (
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] sav_pos,
  input  logic          raw_mode,
  input  logic [RW-1:0] raw_start,
  input  logic [RW-1:0] raw_stop,
  output seg_t          seg,
  output logic [1:0]    idx
);
  localparam int            PADW     = CW - RW - 2;
  localparam logic [CW-1:0] FIX_SPAN = CW'(ACTIVE_LEN + MARK_LEN);
  localparam logic [CW-1:0] MLEN     = CW'(MARK_LEN);

  logic [CW-1:0] raw_sav, raw_eav;
  logic [CW-1:0] sav_at, act_at, eav_at, blk_at;

  generate
    if (PADW > 0) begin : g_pad
      assign raw_sav = {{PADW{1'b0}}, raw_start, 2'b00};
      assign raw_eav = {{PADW{1'b0}}, raw_stop, 2'b00};
    end else begin : g_nopad
      assign raw_sav = {raw_start[CW-3:0], 2'b00};
      assign raw_eav = {raw_stop[CW-3:0], 2'b00};
    end
  endgenerate

  always_comb begin
    sav_at = raw_mode ? raw_sav : sav_pos;
    eav_at = raw_mode ? raw_eav : sav_pos + FIX_SPAN;
    act_at = sav_at + MLEN;
    blk_at = eav_at + MLEN;
    seg    = SEG_BLANK;
    idx    = 2'd0;
    if (cnt >= sav_at && cnt < act_at) begin
      seg = SEG_SAV;
      idx = cnt[1:0] - sav_at[1:0];
    end else if (cnt >= act_at && cnt < eav_at) begin
      seg = SEG_ACT;
    end else if (cnt >= eav_at && cnt < blk_at) begin
      seg = SEG_EAV;
      idx = cnt[1:0] - eav_at[1:0];
    end
  end
endmodule

// File: rtl/vrf_out_stage.sv
module vrf_out_stage
  import vrf_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  seg_t              seg,
  input  logic [1:0]        idx,
  input  logic              test_bypass,
  input  logic [BYTE_W-1:0] adc_byte,
  input  logic [BYTE_W-1:0] pay_data,
  input  logic              pay_valid,
  input  logic              fld_in,
  input  logic              vblk_in,
  output logic [BYTE_W-1:0] vout
);
  logic [1:0]        fv_q;   // {F, V}
  logic              blk_ph; // 0 -> 80h next, 1 -> 10h next
  logic [BYTE_W-1:0] nxt;

  always_comb begin
    nxt = 8'h00;
    unique case (seg)
      SEG_SAV, SEG_EAV: begin
        if (idx == 2'd0)      nxt = 8'hFF;
        else if (idx == 2'd3) nxt = ref_word(fv_q[1], fv_q[0], seg == SEG_EAV);
        else                  nxt = 8'h00;
      end
      SEG_ACT:   nxt = pay_valid ? clamp_byte(pay_data) : 8'h00;
      default:   nxt = blk_ph ? 8'h10 : 8'h80;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vout   <= 8'h10;
      fv_q   <= 2'b01;
      blk_ph <= 1'b0;
    end else begin
      vout <= test_bypass ? adc_byte : nxt;
      if (seg == SEG_EAV && idx == 2'd0) fv_q <= {fld_in, vblk_in};
      if (seg == SEG_EAV)                blk_ph <= 1'b0;
      else if (seg == SEG_BLANK)         blk_ph <= ~blk_ph;
    end
  end
endmodule

// File: rtl/vid_ref_fmt.sv
module vid_ref_fmt
  import vrf_pkg::*;
#(
  parameter int CW         = 12,
  parameter int RW         = 8,
  parameter int ACTIVE_LEN = 1440
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [CW-1:0] line_len,
  input  logic [CW-1:0] sav_pos,
  input  logic          raw_mode,
  input  logic [RW-1:0] raw_start,
  input  logic [RW-1:0] raw_stop,
  input  logic          test_bypass,
  input  logic [7:0]    adc_byte,
  input  logic          fld_in,
  input  logic          vblk_in,
  input  logic [7:0]    pay_data,
  input  logic          pay_valid,
  output logic [7:0]    vout
);
  logic [CW-1:0] cnt;
  seg_t          seg;
  logic [1:0]    idx;

  vrf_line_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst(rst), .line_len(line_len), .cnt(cnt)
  );

  vrf_seg_dec #(.CW(CW), .RW(RW), .ACTIVE_LEN(ACTIVE_LEN)) u_dec (
    .cnt(cnt), .sav_pos(sav_pos), .raw_mode(raw_mode),
    .raw_start(raw_start), .raw_stop(raw_stop), .seg(seg), .idx(idx)
  );

  vrf_out_stage u_out (
    .clk(clk), .rst(rst), .seg(seg), .idx(idx), .test_bypass(test_bypass),
    .adc_byte(adc_byte), .pay_data(pay_data), .pay_valid(pay_valid),
    .fld_in(fld_in), .vblk_in(vblk_in), .vout(vout)
  );
endmodule

// File: rtl/vid_ref_fmt_chk.sv
module vid_ref_fmt_chk (
  input logic       clk,
  input logic       rst,
  input logic       test_bypass,
  input logic [7:0] adc_byte,
  input logic [7:0] vout
);
  logic [2:0] calm;   // clocks since reset or override, saturating
  logic [7:0] h1, h2, h3;
  logic [1:0] last_fv;
  logic       seen;
  logic       quiet, marker;

  assign quiet  = (calm >= 3'd5);
  assign marker = quiet && h3 == 8'hFF && h2 == 8'h00 && h1 == 8'h00;

  always_ff @(posedge clk) begin
    if (rst || test_bypass) begin
      calm <= 3'd0;
      seen <= 1'b0;
    end else begin
      if (calm != 3'd7) calm <= calm + 3'd1;
      if (marker && vout[4]) begin
        last_fv <= vout[6:5];
        seen    <= 1'b1;
      end
    end
    h1 <= vout;
    h2 <= h1;
    h3 <= h2;
  end

  // R1: the byte after a reset clock is 10h
  p_reset_byte_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> vout == 8'h10);

  // R2: a preamble FFh is always followed by 00h
  p_lead_zero_r2: assert property (@(posedge clk) disable iff (rst)
    (quiet && h1 == 8'hFF) |-> vout == 8'h00);

  // R2: the status byte has bit 7 set and consistent protection bits
  p_status_prot_r2: assert property (@(posedge clk) disable iff (rst)
    marker |-> (vout[7] && vout[3:0] == {vout[5] ^ vout[4], vout[6] ^ vout[4],
                                         vout[6] ^ vout[5], vout[6] ^ vout[5] ^ vout[4]}));

  // R8: a start reference repeats the flags of the preceding end reference
  p_sav_flags_r8: assert property (@(posedge clk) disable iff (rst)
    (marker && seen && !vout[4]) |-> vout[6:5] == last_fv);

  // R9: in test override the converter byte appears one clock later
  p_bypass_pass_r9: assert property (@(posedge clk) disable iff (rst)
    ($past(test_bypass) && !$past(rst)) |-> vout == $past(adc_byte));
endmodule

bind vid_ref_fmt vid_ref_fmt_chk u_vrf_chk (
  .clk(clk), .rst(rst), .test_bypass(test_bypass), .adc_byte(adc_byte), .vout(vout)
);

// File: tb/vid_ref_fmt_bench.sv
module vid_ref_fmt_bench;
  localparam int CW = 12;
  localparam int RW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [CW-1:0] line_len = 12'd1470;
  logic [CW-1:0] sav_pos = 12'd8;
  logic          raw_mode = 1'b0;
  logic [RW-1:0] raw_start = 8'd2;
  logic [RW-1:0] raw_stop = 8'd10;
  logic          test_bypass = 1'b0;
  logic [7:0]    adc_byte = 8'h00;
  logic          fld_in = 1'b0;
  logic          vblk_in = 1'b0;
  logic [7:0]    pay_data = 8'h00;
  logic          pay_valid = 1'b0;
  logic [7:0]    vout;

  always #5 clk = ~clk;

  vid_ref_fmt u_vid_ref_fmt (
    .clk(clk), .rst(rst), .line_len(line_len), .sav_pos(sav_pos),
    .raw_mode(raw_mode), .raw_start(raw_start), .raw_stop(raw_stop),
    .test_bypass(test_bypass), .adc_byte(adc_byte), .fld_in(fld_in),
    .vblk_in(vblk_in), .pay_data(pay_data), .pay_valid(pay_valid), .vout(vout)
  );

  // Payload vectors {valid, data, expected output}: R6 and R7
  localparam logic [16:0] VEC [8] = '{
    {1'b1, 8'hA5, 8'hA5}, {1'b1, 8'hFF, 8'hFE}, {1'b1, 8'h00, 8'h01},
    {1'b0, 8'h37, 8'h00}, {1'b1, 8'h80, 8'h80}, {1'b1, 8'hFE, 8'hFE},
    {1'b0, 8'hFF, 8'h00}, {1'b1, 8'h01, 8'h01}
  };

  int errs = 0;
  int chks = 0;
  bit done = 0;

  // Requirement model state
  int       m_sav, m_eav, m_len, m_p, m_l;
  bit       m_bph;
  bit [1:0] m_fv;

  function automatic logic [7:0] status_m(bit f, bit v, bit h);
    return {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
  endfunction

  task automatic check(string req, logic [7:0] got, logic [7:0] exp);
    chks++;
    if (got !== exp) begin
      errs++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic set_model();
    m_len = int'(line_len);
    if (raw_mode) begin
      m_sav = 4 * int'(raw_start);
      m_eav = 4 * int'(raw_stop);
    end else begin
      m_sav = int'(sav_pos);
      m_eav = int'(sav_pos) + 4 + 1440;
    end
  endtask

  task automatic do_reset(int n);
    @(negedge clk);
    rst = 1'b1;
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
      check("R1 reset byte", vout, 8'h10);
    end
    rst = 1'b0;
    set_model();
    m_bph = 0;
    m_fv = 2'b01;
    m_p = 0;
    m_l = 0;
  endtask

  task automatic run(int npos, bit byp);
    string mreq;
    mreq = raw_mode ? "R4 marker" : "R3 marker";
    for (int n = 0; n < npos; n++) begin
      logic [7:0] exp;
      string      req;
      int         p;
      p = m_p;
      fld_in      = ~m_l[0];
      vblk_in     = m_l[0];
      test_bypass = byp;
      adc_byte    = 8'(p * 37 + m_l);
      pay_valid   = 1'b1;
      pay_data    = 8'hFF;
      if (p >= m_sav && p < m_sav + 4) begin
        int i;
        i = p - m_sav;
        exp = (i == 0) ? 8'hFF : (i == 3) ? status_m(m_fv[1], m_fv[0], 1'b0) : 8'h00;
        req = (i == 3) ? "R2 R8 start status" : mreq;
      end else if (p >= m_sav + 4 && p < m_eav) begin
        int k;
        k = (p - m_sav - 4) % 8;
        pay_valid = VEC[k][16];
        pay_data  = VEC[k][15:8];
        exp = VEC[k][7:0];
        req = VEC[k][16] ? "R7 payload" : "R6 null fill";
      end else if (p >= m_eav && p < m_eav + 4) begin
        int i;
        i = p - m_eav;
        if (i == 0) m_fv = {fld_in, vblk_in};
        exp = (i == 0) ? 8'hFF : (i == 3) ? status_m(m_fv[1], m_fv[0], 1'b1) : 8'h00;
        req = (i == 3) ? "R2 R8 end status" : mreq;
        m_bph = 0;
      end else begin
        exp = m_bph ? 8'h10 : 8'h80;
        req = "R5 blanking";
        m_bph = ~m_bph;
      end
      if (byp) begin
        exp = adc_byte;
        req = "R9 override";
      end
      @(posedge clk);
      @(negedge clk);
      check({req, " R10"}, vout, exp);
      m_p = m_p + 1;
      if (m_p == m_len) begin
        m_p = 0;
        m_l = m_l + 1;
      end
    end
    test_bypass = 1'b0;
  endtask

  initial begin
    // Fixed 1440-clock region, two lines with flags changing per line
    do_reset(3);
    run(2 * 1470, 1'b0);
    // Test override for a full line, then normal output resumes
    run(1470, 1'b1);
    run(1470, 1'b0);
    // Partial line, then a mid-line reset into raw mode
    run(700, 1'b0);
    raw_mode  = 1'b1;
    raw_start = 8'd2;
    raw_stop  = 8'd10;
    line_len  = 12'd60;
    do_reset(2);
    run(3 * 60, 1'b0);
    // Raw region of minimum span: the start reference runs straight into the end reference
    raw_start = 8'd3;
    raw_stop  = 8'd4;
    line_len  = 12'd40;
    do_reset(1);
    run(2 * 40, 1'b0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, chks);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      errs++;
      chks++;
      $display("FAIL watchdog (R1-R10 run): got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errs, chks);
      $finish;
    end
  end
endmodule